// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O Port

This block runs one eight-bit I/O port from a byte-wide special-function-register bus. Four byte registers configure it: an output latch, a per-pin high-drive control, a per-pin direction and a per-pin select that hands the pin to another peripheral. Writes from the bus update these registers. Reads return the register contents. A read at the latch address instead returns the levels sampled on the pins.

Each pin has four controls towards its pad: output enable, output value, a source-current boost and a sink-current boost. Odd pins in high-drive mode get the source boost and even pins get the sink boost. When a pin is handed to a peripheral, that peripheral's enable and value take the place of the direction bit and the latch. Pin levels pass through a two-flop synchronizer. The synchronized levels serve the bus reads and are also sent back to the peripherals.

Top module: `gpio_port_ctl`

## Requirements
- R1: Reset values: latch 0xFF, drive register 0x00, direction register 0xFF, select register 0x00. After reset every pin's output enable is 0 and every output value is 1.
- R2: Bus addresses: latch at 0x80, drive register at 0x93, direction at 0x94, select at 0x95. A write stores the byte, and a read of 0x93, 0x94 or 0x95 returns the stored byte.
- R3: For a pin whose select bit is 0, output enable equals the inverse of its direction bit (0 = output, 1 = input), and output value equals its latch bit.
- R4: For a pin whose select bit is 1, output enable and output value come from that pin's peripheral enable and value inputs, whatever the direction and latch bits hold.
- R5: A drive bit of 0 enables high drive for its pin. It raises the source boost on odd pins (mask 0xAA) and the sink boost on even pins (mask 0x55). The other boost of that pin stays 0, and a drive bit of 1 clears both boosts.
- R6: A read of 0x80 returns the pin levels as they stood two clock edges earlier, through a two-stage synchronizer. An undriven pin reads 1.
- R7: The synchronized pin levels appear on the peripheral input bus with the same two-edge latency.
- R8: A read of any address other than the four mapped ones returns 0x00.
- R9: A write takes effect at the clock edge that samples the write strobe. Before that edge the register and the pin controls keep their old values.
- R10: A write to an unmapped address changes no register and no pin control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_src_boost | output | 8 | Per-pin high source-current strobe |
| pad_sink_boost | output | 8 | Per-pin high sink-current strobe |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| alt_in | output | 8 | Synchronized pin levels for peripherals |

## Verification
A write to the latch and a read of the latch address can fall in the same cycle. The read returns sampled pin levels and not the latch, so the bench does both at once on pins set as outputs. It expects the old level during the write cycle and for one more edge, and the new byte only after the second synchronizer edge. Pull-up-only pins and externally driven pins are swept the same way, and the peripheral input bus is compared against the same expected values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    SEL_LATCH = 3'd0,
    SEL_DRIVE = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_ALT   = 3'd3,
    SEL_NONE  = 3'd4
  } reg_sel_e;

  // Source boost goes to odd pins, sink boost to even pins.
  function automatic logic pin_is_odd(input int idx);
    return (idx % 2) == 1;
  endfunction

  // High drive is enabled by a cleared drive bit.
  function automatic logic high_drive_on(input logic drv_bit);
    return !drv_bit;
  endfunction

  // Output enable from register state, or from the peripheral when selected.
  function automatic logic pick_oe(input logic sel, input logic dir_bit,
                                   input logic per_oe);
    return sel ? per_oe : !dir_bit;
  endfunction

  function automatic logic pick_val(input logic sel, input logic lat_bit,
                                    input logic per_val);
    return sel ? per_val : lat_bit;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int             W       = 8,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int           W        = 8,
  parameter int           AW       = 8,
  parameter logic [AW-1:0] A_LATCH = 8'h80,
  parameter logic [AW-1:0] A_DRIVE = 8'h93,
  parameter logic [AW-1:0] A_DIR   = 8'h94,
  parameter logic [AW-1:0] A_ALT   = 8'h95,
  parameter logic [W-1:0] RV_LATCH = '1,
  parameter logic [W-1:0] RV_DRIVE = '0,
  parameter logic [W-1:0] RV_DIR   = '1,
  parameter logic [W-1:0] RV_ALT   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  lat_q,
  output logic [W-1:0]  drv_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  alt_q,
  output reg_sel_e      sel,
  output logic          unmapped
);

  always_comb begin
    if (addr == A_LATCH)      sel = SEL_LATCH;
    else if (addr == A_DRIVE) sel = SEL_DRIVE;
    else if (addr == A_DIR)   sel = SEL_DIR;
    else if (addr == A_ALT)   sel = SEL_ALT;
    else                      sel = SEL_NONE;
  end

  assign unmapped = (sel == SEL_NONE);

  logic wr_lat, wr_drv, wr_dir, wr_alt;
  assign wr_lat = wr && (sel == SEL_LATCH);
  assign wr_drv = wr && (sel == SEL_DRIVE);
  assign wr_dir = wr && (sel == SEL_DIR);
  assign wr_alt = wr && (sel == SEL_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= RV_LATCH;
      drv_q <= RV_DRIVE;
      dir_q <= RV_DIR;
      alt_q <= RV_ALT;
    end else begin
      if (wr_lat) lat_q <= wdata;
      if (wr_drv) drv_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      if (wr_alt) alt_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LATCH: rdata = pin_sync;
      SEL_DRIVE: rdata = drv_q;
      SEL_DIR:   rdata = dir_q;
      SEL_ALT:   rdata = alt_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] lat,
  input  logic [W-1:0] drv,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] alt_sel,
  input  logic [W-1:0] per_val,
  input  logic [W-1:0] per_oe,
  output logic [W-1:0] oe,
  output logic [W-1:0] val,
  output logic [W-1:0] src_boost,
  output logic [W-1:0] sink_boost
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hd;
    assign oe[i]  = pick_oe(alt_sel[i], dir[i], per_oe[i]);
    assign val[i] = pick_val(alt_sel[i], lat[i], per_val[i]);
    assign hd     = high_drive_on(drv[i]);
    if (pin_is_odd(i)) begin : g_odd
      assign src_boost[i]  = hd;
      assign sink_boost[i] = 1'b0;
    end else begin : g_even
      assign src_boost[i]  = 1'b0;
      assign sink_boost[i] = hd;
    end
  end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
#(
  parameter int            W          = 8,
  parameter int            AW         = 8,
  parameter int            SYNC_DEPTH = 2,
  parameter logic [AW-1:0] A_LATCH    = 8'h80,
  parameter logic [AW-1:0] A_DRIVE    = 8'h93,
  parameter logic [AW-1:0] A_DIR      = 8'h94,
  parameter logic [AW-1:0] A_ALT      = 8'h95
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_src_boost,
  output logic [W-1:0]  pad_sink_boost,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  alt_oe,
  output logic [W-1:0]  alt_in
);

  // Named internal state, visible to the bound checker.
  logic [W-1:0] pin_sync;
  logic [W-1:0] lat_q, drv_q, dir_q, alt_q;
  reg_sel_e     sel;
  logic         unmapped;

  gpio_sync #(.W(W), .STAGES(SYNC_DEPTH), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_regs #(
    .W(W), .AW(AW),
    .A_LATCH(A_LATCH), .A_DRIVE(A_DRIVE), .A_DIR(A_DIR), .A_ALT(A_ALT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .lat_q    (lat_q),
    .drv_q    (drv_q),
    .dir_q    (dir_q),
    .alt_q    (alt_q),
    .sel      (sel),
    .unmapped (unmapped)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .lat        (lat_q),
    .drv        (drv_q),
    .dir        (dir_q),
    .alt_sel    (alt_q),
    .per_val    (alt_out),
    .per_oe     (alt_oe),
    .oe         (pad_oe),
    .val        (pad_out),
    .src_boost  (pad_src_boost),
    .sink_boost (pad_sink_boost)
  );

  assign alt_in = pin_sync;

endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int            W       = 8,
  parameter int            AW      = 8,
  parameter logic [AW-1:0] A_LATCH = 8'h80,
  parameter logic [AW-1:0] A_DRIVE = 8'h93,
  parameter logic [AW-1:0] A_DIR   = 8'h94,
  parameter logic [AW-1:0] A_ALT   = 8'h95
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  alt_in,
  input logic [W-1:0]  pad_src_boost,
  input logic [W-1:0]  pad_sink_boost,
  input logic [W-1:0]  lat_q,
  input logic [W-1:0]  drv_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  alt_q,
  input logic          unmapped
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R7
  sync_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> alt_in == $past(pad_in, 2));

  // R6
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && bus_addr == A_LATCH) |-> bus_rdata == $past(pad_in, 2));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> bus_rdata == '0);

  // R9
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> dir_q == $past(bus_wdata));

  // R9
  drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DRIVE) |=> drv_q == $past(bus_wdata));

  // R9
  alt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ALT) |=> alt_q == $past(bus_wdata));

  // R9
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LATCH) |=> lat_q == $past(bus_wdata));

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(lat_q) && $stable(drv_q) &&
                              $stable(dir_q) && $stable(alt_q)));

  // R5
  boost_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_src_boost & pad_sink_boost) == '0);

  // R5
  boost_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_src_boost | pad_sink_boost) == ~drv_q);

endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(
  .W(W), .AW(AW),
  .A_LATCH(A_LATCH), .A_DRIVE(A_DRIVE), .A_DIR(A_DIR), .A_ALT(A_ALT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .pad_in         (pad_in),
  .alt_in         (alt_in),
  .pad_src_boost  (pad_src_boost),
  .pad_sink_boost (pad_sink_boost),
  .lat_q          (lat_q),
  .drv_q          (drv_q),
  .dir_q          (dir_q),
  .alt_q          (alt_q),
  .unmapped       (unmapped)
);

// File: tb/gpio_port_ctl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_lvl;
  logic [7:0] pad_oe, pad_out, pad_src_boost, pad_sink_boost;
  logic [7:0] alt_out = 8'h00;
  logic [7:0] alt_oe = 8'h00;
  logic [7:0] alt_in;

  // Pad model: a driven output wins, else an external driver, else the weak pull-up.
  logic [7:0] ext_en = 8'h00;
  logic [7:0] ext_val = 8'h00;
  assign pad_lvl = (pad_oe & pad_out) | (~pad_oe & ext_en & ext_val) | (~pad_oe & ~ext_en);

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port_ctl u_gpio_port_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_lvl),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_src_boost(pad_src_boost),
    .pad_sink_boost(pad_sink_boost), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in)
  );

  localparam logic [7:0] A_LAT = 8'h80, A_DRV = 8'h93, A_DIR = 8'h94, A_ALT = 8'h95;
  localparam logic [7:0] ODD_MASK = 8'hAA, EVEN_MASK = 8'h55;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; the next rising edge performs the write.
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=%h exp=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] lat_v, aout_v, aoe_v, dir_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    bus_read(A_DRV, rd); chk("R1 drive reset", rd, 8'h00);
    bus_read(A_DIR, rd); chk("R1 dir reset", rd, 8'hFF);
    bus_read(A_ALT, rd); chk("R1 alt reset", rd, 8'h00);
    bus_read(A_LAT, rd); chk("R1 pins pulled up", rd, 8'hFF);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 out reset", pad_out, 8'hFF);
    chk("R5 src boost at reset", pad_src_boost, ODD_MASK);
    chk("R5 sink boost at reset", pad_sink_boost, EVEN_MASK);

    // R2: write and read back configuration registers
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pat;
      pat = 8'h3C ^ 8'(p * 8'h51);
      bus_write(A_DRV, pat);       bus_read(A_DRV, rd); chk("R2 drive rw", rd, pat);
      bus_write(A_DIR, ~pat);      bus_read(A_DIR, rd); chk("R2 dir rw", rd, ~pat);
      bus_write(A_ALT, pat ^ 8'hF0); bus_read(A_ALT, rd); chk("R2 alt rw", rd, pat ^ 8'hF0);
    end
    bus_write(A_ALT, 8'h00);

    // R3: sweep every direction byte with alt clear
    lat_v = 8'h5A;
    bus_write(A_LAT, lat_v);
    for (int v = 0; v < 256; v++) begin
      bus_write(A_DIR, 8'(v));
      chk("R3 oe from dir", pad_oe, ~8'(v));
      chk("R3 out from latch", pad_out, lat_v);
    end

    // R4: sweep every select byte; peripheral controls win where selected
    lat_v = 8'h0F; aout_v = 8'hC3; aoe_v = 8'h96; dir_v = 8'h33;
    bus_write(A_LAT, lat_v);
    bus_write(A_DIR, dir_v);
    alt_out = aout_v; alt_oe = aoe_v;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] s;
      s = 8'(v);
      bus_write(A_ALT, s);
      chk("R4 oe override", pad_oe, (s & aoe_v) | (~s & ~dir_v));
      chk("R4 out override", pad_out, (s & aout_v) | (~s & lat_v));
    end
    bus_write(A_ALT, 8'h00);

    // R5: sweep every drive byte
    for (int v = 0; v < 256; v++) begin
      bus_write(A_DRV, 8'(v));
      chk("R5 src boost", pad_src_boost, ~8'(v) & ODD_MASK);
      chk("R5 sink boost", pad_sink_boost, ~8'(v) & EVEN_MASK);
    end

    // R6/R7: external levels on input pins, two-edge latency
    bus_write(A_DIR, 8'hFF);
    ext_en = 8'hFF;
    for (int v = 0; v < 16; v++) begin
      logic [7:0] prev, nxt;
      bus_read(A_LAT, prev);
      nxt = 8'(v * 37 + 11);
      ext_val = nxt;
      @(negedge clk);
      bus_read(A_LAT, rd); chk("R6 one edge still old", rd, prev);
      chk("R7 one edge still old", alt_in, prev);
      @(negedge clk);
      bus_read(A_LAT, rd); chk("R6 two edges new", rd, nxt);
      chk("R7 two edges new", alt_in, nxt);
    end
    // R6: partial external drive, rest pulled up
    ext_en = 8'h0F; ext_val = 8'h00;
    repeat (2) @(negedge clk);
    bus_read(A_LAT, rd); chk("R6 pull-up on undriven pins", rd, 8'hF0);
    ext_en = 8'h00;

    // R8: unmapped reads
    begin
      logic [7:0] ua [6];
      ua = '{8'h00, 8'h7F, 8'h81, 8'h92, 8'h96, 8'hFF};
      for (int k = 0; k < 6; k++) begin
        bus_read(ua[k], rd); chk("R8 unmapped read", rd, 8'h00);
      end
    end

    // R9: write visible only after its edge
    bus_write(A_DIR, 8'hF0);
    @(negedge clk);
    bus_addr = A_DIR; bus_wdata = 8'h0F; bus_wr = 1'b1;
    #1;
    chk("R9 dir before edge", bus_rdata, 8'hF0);
    chk("R9 oe before edge", pad_oe, 8'h0F);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    chk("R9 dir after edge", bus_rdata, 8'h0F);
    chk("R9 oe after edge", pad_oe, 8'hF0);

    // Collision: latch write while reading the latch address (R9, R6)
    bus_write(A_LAT, 8'hFF);
    bus_write(A_DIR, 8'h00);
    repeat (3) @(negedge clk);
    bus_addr = A_LAT; bus_wdata = 8'h3C; bus_wr = 1'b1;
    #1;
    chk("R6 read during latch write", bus_rdata, 8'hFF);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    chk("R9 pad out after write edge", pad_out, 8'h3C);
    chk("R6 read one edge after write", bus_rdata, 8'hFF);
    @(negedge clk); #1;
    chk("R6 read two edges after write", bus_rdata, 8'hFF);
    @(negedge clk); #1;
    chk("R6 read three edges after write", bus_rdata, 8'h3C);

    // R10: unmapped writes change nothing
    bus_write(A_DRV, 8'hA5);
    bus_write(A_ALT, 8'h00);
    bus_write(8'h90, 8'h00);
    bus_write(8'h96, 8'hFF);
    bus_write(8'h00, 8'h5A);
    bus_read(A_DRV, rd); chk("R10 drive kept", rd, 8'hA5);
    bus_read(A_DIR, rd); chk("R10 dir kept", rd, 8'h00);
    bus_read(A_ALT, rd); chk("R10 alt kept", rd, 8'h00);
    chk("R10 out kept", pad_out, 8'h3C);
    chk("R10 oe kept", pad_oe, 8'hFF);

    finish_run();
  end

endmodule